// File: doc/BRIEF.md
# PMIC Bus Software Command Channel

This block lets software issue single register reads and writes to a power-management IC over a serial power-management bus. Software sees a small word-indexed register file: a command register, a write-data register, a read-data register, a valid-clear register, a status register that reports the channel state, and an init register. Writing a legal command while the channel is idle captures the opcode class, direction, slave ID, byte count and target address, and raises a request on a bus-side port. The port is modelled as a request/acknowledge handshake followed by a one-cycle done pulse that may carry read data.

A write finishes on the done pulse and the channel goes back to idle. A read parks the channel in a wait-for-valid-clear state with the returned bytes in the read-data register. It stays there until software writes 1 to bit 0 of the valid-clear register. A command that arrives while the channel is busy, or that is malformed, is dropped. In that case a sticky error flag is raised.

Top module: `pmic_cmd_channel`

## Requirements
- R1: While reset is held, the status word reads 0 and busReq is low. On the first clock edge after reset is released, bit 15 of the init register (word 5) becomes 1 and stays 1.
- R2: The command register is word 0. Its fields are: opcode class in bits [31:30] (0 zero-register write, 1 short, 2 extended, 3 extended-long), write flag in bit 29 (1 = write), slave ID in bits [27:24], byte count minus one in bits [19:16], and address in bits [15:0]. A legal command written in IDLE makes busReq high on the next cycle, with busOpc, busWrite, busSid, busBc and busAddr carrying those fields.
- R3: The status register is word 4 and reports the state in bits [3:1]: IDLE=0, REQ=1, WFDLE=2, WFVLDCLR=3. In REQ, busReq and the bus fields hold until busAck is sampled high. The state then moves to WFDLE and busReq drops.
- R4: On a read, a busDone sampled in WFDLE moves the state to WFVLDCLR and loads busRdata into the read-data register (word 2), zero-extended. With byte count 0 only bits [7:0] are kept.
- R5: In WFVLDCLR the channel stays put until the valid-clear register (word 3) is written with bit 0 set. That write returns it to IDLE. A valid-clear write with bit 0 clear has no effect.
- R6: The write-data register is word 1. While a write command is in flight, busWdata carries its bits [15:0], with bits [15:8] forced to 0 when the byte count is 0. A busDone in WFDLE for a write returns the channel directly to IDLE.
- R7: A command written while the channel is not IDLE is ignored: the state and bus fields are unchanged. It also sets the sticky error flag at status bit 8. The flag stays set until the status register is written with bit 8 set.
- R8: busAck outside REQ and busDone outside WFDLE have no effect on the state.
- R9: A command whose byte count field exceeds 1, or with any of bits 28 or [23:20] set, is ignored even in IDLE and sets the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word index |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr (combinational) |
| busReq | output | 1 | Request to the bus port |
| busOpc | output | 2 | Opcode class of the current command |
| busWrite | output | 1 | 1 for a write command |
| busSid | output | 4 | Slave ID |
| busBc | output | 4 | Byte count minus one |
| busAddr | output | 16 | Register address on the PMIC |
| busWdata | output | 16 | Write bytes, masked by byte count |
| busAck | input | 1 | Bus port accepted the request |
| busDone | input | 1 | Bus port finished the transfer (one-cycle pulse) |
| busRdata | input | 16 | Read bytes returned with busDone |

## Verification
A behavioural model of the channel runs beside the design and is compared with it after every clock edge. Reads are tried with one and with two bytes, so that byte-lane masking is separated from plain capture. Writes are tried with both byte counts and with a full-width write-data word, which shows whether the upper byte leaks. Stray acknowledge and done pulses, commands issued while the channel is busy, and malformed commands issued while it is idle each check one path that must leave the state alone: the REQ hold, the idle guard, and the legality decode. Valid-clear writes with bit 0 low and high tell the park state apart from a channel that returns to idle on its own.

// File: rtl/pmic_cmd_pkg.sv
package pmic_cmd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_REQ   = 3'd1,
    ST_WFDLE = 3'd2,
    ST_WFVLD = 3'd3
  } chanState_t;

  // Decoded register-side events, datapath -> control
  typedef struct packed {
    logic cmdWr;
    logic cmdLegal;
    logic vclrWr;
  } regHits_t;

  // Control -> datapath strobes
  typedef struct packed {
    logic loadCmd;
    logic captureRd;
    logic setErr;
  } strobes_t;

  // Register word indices
  localparam int unsigned OFS_CMD    = 0;
  localparam int unsigned OFS_WDATA  = 1;
  localparam int unsigned OFS_RDATA  = 2;
  localparam int unsigned OFS_VCLR   = 3;
  localparam int unsigned OFS_STATUS = 4;
  localparam int unsigned OFS_INIT   = 5;

  // Bit positions inside the command and status words
  localparam int unsigned POS_OPC   = 30;
  localparam int unsigned POS_WR    = 29;
  localparam int unsigned POS_SID   = 24;
  localparam int unsigned POS_BC    = 16;
  localparam int unsigned POS_STATE = 1;
  localparam int unsigned POS_ERR   = 8;
  localparam int unsigned POS_INIT  = 15;

endpackage

// File: rtl/pmic_cmd_ctrl.sv
module pmic_cmd_ctrl
  import pmic_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  regHits_t   hits,
  input  logic       curIsWrite,
  input  logic       vclrBit,
  input  logic       busAck,
  input  logic       busDone,
  output chanState_t state,
  output strobes_t   strobes,
  output logic       busReq
);

  chanState_t stateQ, stateD;

  always_comb begin
    stateD            = stateQ;
    strobes.loadCmd   = 1'b0;
    strobes.captureRd = 1'b0;
    strobes.setErr    = 1'b0;
    if (hits.cmdWr) begin
      if (stateQ == ST_IDLE && hits.cmdLegal) strobes.loadCmd = 1'b1;
      else                                    strobes.setErr  = 1'b1;
    end
    unique case (stateQ)
      ST_IDLE:  if (strobes.loadCmd) stateD = ST_REQ;
      ST_REQ:   if (busAck) stateD = ST_WFDLE;
      ST_WFDLE: if (busDone) begin
        if (curIsWrite) stateD = ST_IDLE;
        else begin
          stateD            = ST_WFVLD;
          strobes.captureRd = 1'b1;
        end
      end
      ST_WFVLD: if (hits.vclrWr && vclrBit) stateD = ST_IDLE;
      default:  stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign state  = stateQ;
  assign busReq = (stateQ == ST_REQ);

endmodule

// File: rtl/pmic_cmd_dp.sv
module pmic_cmd_dp
  import pmic_cmd_pkg::*;
#(
  parameter int unsigned REG_AW    = 3,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned BUS_AW    = 16,
  parameter int unsigned SID_W     = 4,
  parameter int unsigned BC_W      = 4,
  parameter int unsigned BYTES_MAX = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [REG_AW-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWdata,
  output logic [DATA_W-1:0]    regRdata,
  input  chanState_t           state,
  input  strobes_t             strobes,
  output regHits_t             hits,
  output logic                 curIsWrite,
  output logic                 vclrBit,
  output logic [1:0]           busOpc,
  output logic                 busWrite,
  output logic [SID_W-1:0]     busSid,
  output logic [BC_W-1:0]      busBc,
  output logic [BUS_AW-1:0]    busAddr,
  output logic [8*BYTES_MAX-1:0] busWdata,
  input  logic [8*BYTES_MAX-1:0] busRdata,
  output logic                 errFlag,
  output logic                 initDone
);

  localparam int unsigned BUS_DW = 8 * BYTES_MAX;
  localparam logic [DATA_W-1:0] FIELD_MASK =
      (DATA_W'(3) << POS_OPC) | (DATA_W'(1) << POS_WR) |
      (((DATA_W'(1) << SID_W) - 1) << POS_SID) |
      (((DATA_W'(1) << BC_W) - 1) << POS_BC) |
      ((DATA_W'(1) << BUS_AW) - 1);
  localparam logic [DATA_W-1:0] RSV_MASK = ~FIELD_MASK;

  logic [1:0]        opcQ;
  logic              wrQ;
  logic [SID_W-1:0]  sidQ;
  logic [BC_W-1:0]   bcQ;
  logic [BUS_AW-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ, rdataQ;
  logic              errQ, initQ;
  logic [BUS_DW-1:0] rdMasked;

  logic [BC_W-1:0] newBc;
  assign newBc = regWdata[POS_BC +: BC_W];

  assign hits.cmdWr    = regWrEn && (regAddr == REG_AW'(OFS_CMD));
  assign hits.cmdLegal = ((regWdata & RSV_MASK) == '0) &&
                         (newBc <= BC_W'(BYTES_MAX - 1));
  assign hits.vclrWr   = regWrEn && (regAddr == REG_AW'(OFS_VCLR));
  assign vclrBit       = regWdata[0];

  logic errClr;
  assign errClr = regWrEn && (regAddr == REG_AW'(OFS_STATUS)) && regWdata[POS_ERR];

  // Byte-lane masking by byte count, one lane per generate iteration
  for (genvar g = 0; g < BYTES_MAX; g++) begin : g_lane
    logic laneOn;
    assign laneOn = (BC_W'(g) <= bcQ);
    assign busWdata[8*g +: 8] = laneOn ? wdataQ[8*g +: 8] : 8'h00;
    assign rdMasked[8*g +: 8] = laneOn ? busRdata[8*g +: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opcQ   <= '0;
      wrQ    <= 1'b0;
      sidQ   <= '0;
      bcQ    <= '0;
      addrQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
      errQ   <= 1'b0;
      initQ  <= 1'b0;
    end else begin
      initQ <= 1'b1;
      if (strobes.loadCmd) begin
        opcQ  <= regWdata[POS_OPC +: 2];
        wrQ   <= regWdata[POS_WR];
        sidQ  <= regWdata[POS_SID +: SID_W];
        bcQ   <= newBc;
        addrQ <= regWdata[BUS_AW-1:0];
      end
      if (regWrEn && regAddr == REG_AW'(OFS_WDATA)) wdataQ <= regWdata;
      if (strobes.captureRd) rdataQ <= {{(DATA_W-BUS_DW){1'b0}}, rdMasked};
      if (strobes.setErr)    errQ <= 1'b1;
      else if (errClr)       errQ <= 1'b0;
    end
  end

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      REG_AW'(OFS_CMD):    regRdata = {opcQ, wrQ, 1'b0, sidQ, 4'b0, bcQ, addrQ};
      REG_AW'(OFS_WDATA):  regRdata = wdataQ;
      REG_AW'(OFS_RDATA):  regRdata = rdataQ;
      REG_AW'(OFS_STATUS): begin
        regRdata[POS_STATE +: 3] = state;
        regRdata[POS_ERR]        = errQ;
      end
      REG_AW'(OFS_INIT):   regRdata[POS_INIT] = initQ;
      default:             regRdata = '0;
    endcase
  end

  assign curIsWrite = wrQ;
  assign busOpc     = opcQ;
  assign busWrite   = wrQ;
  assign busSid     = sidQ;
  assign busBc      = bcQ;
  assign busAddr    = addrQ;
  assign errFlag    = errQ;
  assign initDone   = initQ;

endmodule

// File: rtl/pmic_cmd_channel.sv
module pmic_cmd_channel
  import pmic_cmd_pkg::*;
#(
  parameter int unsigned REG_AW    = 3,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned BUS_AW    = 16,
  parameter int unsigned SID_W     = 4,
  parameter int unsigned BC_W      = 4,
  parameter int unsigned BYTES_MAX = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    regWrEn,
  input  logic [REG_AW-1:0]       regAddr,
  input  logic [DATA_W-1:0]       regWdata,
  output logic [DATA_W-1:0]       regRdata,
  output logic                    busReq,
  output logic [1:0]              busOpc,
  output logic                    busWrite,
  output logic [SID_W-1:0]        busSid,
  output logic [BC_W-1:0]         busBc,
  output logic [BUS_AW-1:0]       busAddr,
  output logic [8*BYTES_MAX-1:0]  busWdata,
  input  logic                    busAck,
  input  logic                    busDone,
  input  logic [8*BYTES_MAX-1:0]  busRdata
);

  chanState_t state;
  strobes_t   strobes;
  regHits_t   hits;
  logic       curIsWrite, vclrBit, errFlag, initDone;

  pmic_cmd_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .hits       (hits),
    .curIsWrite (curIsWrite),
    .vclrBit    (vclrBit),
    .busAck     (busAck),
    .busDone    (busDone),
    .state      (state),
    .strobes    (strobes),
    .busReq     (busReq)
  );

  pmic_cmd_dp #(
    .REG_AW(REG_AW), .DATA_W(DATA_W), .BUS_AW(BUS_AW),
    .SID_W(SID_W), .BC_W(BC_W), .BYTES_MAX(BYTES_MAX)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWdata   (regWdata),
    .regRdata   (regRdata),
    .state      (state),
    .strobes    (strobes),
    .hits       (hits),
    .curIsWrite (curIsWrite),
    .vclrBit    (vclrBit),
    .busOpc     (busOpc),
    .busWrite   (busWrite),
    .busSid     (busSid),
    .busBc      (busBc),
    .busAddr    (busAddr),
    .busWdata   (busWdata),
    .busRdata   (busRdata),
    .errFlag    (errFlag),
    .initDone   (initDone)
  );

endmodule

// File: rtl/pmic_cmd_channel_chk.sv
module pmic_cmd_channel_chk #(
  parameter int unsigned REG_AW = 3,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BUS_AW = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [REG_AW-1:0] regAddr,
  input logic [DATA_W-1:0] regWdata,
  input logic              busReq,
  input logic              busAck,
  input logic              busDone,
  input logic [BUS_AW-1:0] busAddr,
  input logic [2:0]        stateBits,
  input logic              errFlag,
  input logic              initDone
);

  logic vclrSet, errClrWr;
  assign vclrSet  = regWrEn && (regAddr == REG_AW'(3)) && regWdata[0];
  assign errClrWr = regWrEn && (regAddr == REG_AW'(4)) && regWdata[8];

  // R3: request holds with stable address until acknowledged
  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> busReq && $stable(busAddr));

  // R3: acknowledge drops the request and enters WFDLE
  a_r3_ack_drop: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busAck |=> !busReq && stateBits == 3'd2);

  // R5: park state is left only through a valid-clear write with bit 0 set
  a_r5_park: assert property (@(posedge clk) disable iff (!rstN)
    stateBits == 3'd3 && !vclrSet |=> stateBits == 3'd3);

  // R7: error flag is sticky until explicitly cleared
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errFlag && !errClrWr |=> errFlag);

  // R8: done outside WFDLE leaves idle untouched
  a_r8_idle_done: assert property (@(posedge clk) disable iff (!rstN)
    stateBits == 3'd0 && busDone && !regWrEn |=> stateBits == 3'd0);

  // R1: init flag never falls once set
  a_r1_init_stays: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);

endmodule

bind pmic_cmd_channel pmic_cmd_channel_chk #(
  .REG_AW(REG_AW), .DATA_W(DATA_W), .BUS_AW(BUS_AW)
) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regWdata  (regWdata),
  .busReq    (busReq),
  .busAck    (busAck),
  .busDone   (busDone),
  .busAddr   (busAddr),
  .stateBits (state),
  .errFlag   (errFlag),
  .initDone  (initDone)
);

// File: tb/test_pmic_cmd_channel.sv
`timescale 1ns/1ps
module test_pmic_cmd_channel;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = 3'd4;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        busReq, busWrite, busAck = 1'b0, busDone = 1'b0;
  logic [1:0]  busOpc;
  logic [3:0]  busSid, busBc;
  logic [15:0] busAddr, busWdata, busRdata = '0;

  int nChecks = 0, nFails = 0;
  string curReq = "R1";

  always #5 clk = ~clk;

  pmic_cmd_channel i_pmic_cmd_channel (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .busReq(busReq),
    .busOpc(busOpc), .busWrite(busWrite), .busSid(busSid), .busBc(busBc),
    .busAddr(busAddr), .busWdata(busWdata), .busAck(busAck),
    .busDone(busDone), .busRdata(busRdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          ms = 0;
  bit          mErr = 0, mInit = 0;
  int unsigned mOpc, mRw, mSid, mBc, mAddr, mWdata = 0, mRdata = 0;

  always @(posedge clk) begin
    int unsigned v;
    v = regWdata;
    if (!rstN) begin
      ms = 0; mErr = 0; mInit = 0; mWdata = 0; mRdata = 0;
      mOpc = 0; mRw = 0; mSid = 0; mBc = 0; mAddr = 0;
    end else begin
      mInit = 1;
      if (regWrEn && regAddr == 3'd1) mWdata = v;
      if (regWrEn && regAddr == 3'd4 && v[8]) mErr = 0;
      if (regWrEn && regAddr == 3'd0) begin
        if (ms == 0 && (v & 32'h10F0_0000) == 0 && ((v >> 16) & 15) <= 1) begin
          mOpc = v >> 30; mRw = (v >> 29) & 1; mSid = (v >> 24) & 15;
          mBc = (v >> 16) & 15; mAddr = v & 16'hFFFF; ms = 1;
        end else mErr = 1;
      end else if (ms == 1 && busAck) ms = 2;
      else if (ms == 2 && busDone) begin
        if (mRw == 1) ms = 0;
        else begin
          ms = 3;
          mRdata = (mBc == 0) ? (busRdata & 16'h00FF) : busRdata;
        end
      end else if (ms == 3 && regWrEn && regAddr == 3'd3 && v[0]) ms = 0;
    end
    #2;
    chk({curReq, " busReq"}, 32'(busReq), 32'(ms == 1));
    if (ms == 1) begin
      chk({curReq, " fields"}, {busOpc, 1'b0, busWrite, busSid, busBc, busAddr},
          {mOpc[1:0], 1'b0, mRw[0], mSid[3:0], mBc[3:0], mAddr[15:0]});
      chk({curReq, " wdata"}, 32'(busWdata),
          (mBc == 0) ? (mWdata & 32'hFF) : (mWdata & 32'hFFFF));
    end
    if (regAddr == 3'd4)
      chk({curReq, " status"}, regRdata, (32'(mErr) << 8) | (32'(ms) << 1));
  end

  // ---------------- stimulus helpers ----------------
  task automatic wrReg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 3'd4; regWdata = '0;
  endtask

  task automatic rdReg(input string req, input logic [2:0] a, input logic [31:0] exp);
    @(negedge clk);
    regAddr = a;
    #1 chk(req, regRdata, exp);
    regAddr = 3'd4;
  endtask

  task automatic pulseAck();
    @(negedge clk); busAck = 1'b1;
    @(negedge clk); busAck = 1'b0;
  endtask

  task automatic pulseDone(input logic [15:0] d);
    @(negedge clk); busDone = 1'b1; busRdata = d;
    @(negedge clk); busDone = 1'b0; busRdata = '0;
  endtask

  function automatic logic [31:0] mkCmd(input int opc, input int rw, input int sid,
                                        input int bc, input int addr);
    return (32'(opc) << 30) | (32'(rw) << 29) | (32'(sid) << 24) |
           (32'(bc) << 16) | 32'(addr & 16'hFFFF);
  endfunction

  initial begin
    #(200000 * 10);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    #1 chk("R1 status in reset", regRdata, 32'h0);
    chk("R1 busReq in reset", 32'(busReq), 32'h0);
    rstN = 1'b1;
    rdReg("R1 init done", 3'd5, 32'h0000_8000);

    // R2/R3/R4/R5: two-byte short read
    curReq = "R2";
    wrReg(3'd0, mkCmd(1, 0, 5, 1, 16'h0012));
    chk("R2 busReq after cmd", 32'(busReq), 32'h1);
    chk("R2 busAddr", 32'(busAddr), 32'h12);
    chk("R2 busSid", 32'(busSid), 32'h5);
    curReq = "R3";
    repeat (2) @(negedge clk);
    rdReg("R3 REQ holds", 3'd4, 32'h2);
    pulseAck();
    rdReg("R3 WFDLE", 3'd4, 32'h4);
    curReq = "R4";
    pulseDone(16'hBEEF);
    rdReg("R4 park", 3'd4, 32'h6);
    rdReg("R4 rdata 2 bytes", 3'd2, 32'h0000_BEEF);
    curReq = "R5";
    wrReg(3'd3, 32'h0000_0002);
    rdReg("R5 vclr bit0 low ignored", 3'd4, 32'h6);
    wrReg(3'd3, 32'h1);
    rdReg("R5 back to idle", 3'd4, 32'h0);

    // R4: one-byte extended-long read masks the upper byte
    curReq = "R4";
    wrReg(3'd0, mkCmd(3, 0, 9, 0, 16'h03A7));
    pulseAck();
    pulseDone(16'h12AB);
    rdReg("R4 rdata 1 byte", 3'd2, 32'h0000_00AB);
    wrReg(3'd3, 32'h1);

    // R6: two-byte extended write
    curReq = "R6";
    wrReg(3'd1, 32'hFFFF_5A3C);
    wrReg(3'd0, mkCmd(2, 1, 15, 1, 16'h0040));
    chk("R6 busWdata 2 bytes", 32'(busWdata), 32'h5A3C);
    chk("R6 busWrite", 32'(busWrite), 32'h1);
    pulseAck();
    pulseDone(16'h0);
    rdReg("R6 write ends in idle", 3'd4, 32'h0);

    // R6: one-byte zero-register write
    wrReg(3'd0, mkCmd(0, 1, 3, 0, 16'h0000));
    chk("R6 busWdata 1 byte", 32'(busWdata), 32'h003C);
    chk("R6 busOpc", 32'(busOpc), 32'h0);

    // R7: command while busy is ignored
    curReq = "R7";
    wrReg(3'd0, mkCmd(1, 0, 7, 1, 16'h0055));
    chk("R7 busAddr unchanged", 32'(busAddr), 32'h0);
    chk("R7 busSid unchanged", 32'(busSid), 32'h3);
    rdReg("R7 err set, still REQ", 3'd4, 32'h102);
    pulseAck();
    pulseDone(16'h0);
    rdReg("R7 err sticky in idle", 3'd4, 32'h100);
    wrReg(3'd4, 32'h100);
    rdReg("R7 err cleared", 3'd4, 32'h0);

    // R8: stray ack/done
    curReq = "R8";
    pulseAck();
    pulseDone(16'h1234);
    rdReg("R8 idle unchanged", 3'd4, 32'h0);
    wrReg(3'd0, mkCmd(1, 0, 2, 0, 16'h0001));
    pulseDone(16'h1234);
    rdReg("R8 done in REQ ignored", 3'd4, 32'h2);
    pulseAck();
    pulseAck();
    rdReg("R8 ack in WFDLE ignored", 3'd4, 32'h4);
    pulseDone(16'h0077);
    wrReg(3'd3, 32'h1);

    // R9: malformed commands in idle
    curReq = "R9";
    wrReg(3'd0, mkCmd(1, 0, 2, 2, 16'h0001));
    rdReg("R9 bc=2 rejected", 3'd4, 32'h100);
    wrReg(3'd4, 32'h100);
    wrReg(3'd0, mkCmd(1, 0, 2, 0, 16'h0001) | 32'h1000_0000);
    rdReg("R9 reserved bit rejected", 3'd4, 32'h100);
    chk("R9 no request", 32'(busReq), 32'h0);

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule